// File: doc/BRIEF.md
# Multi-Lane SPI Flash Command Sequencer

This block runs one serial-flash command at a time over a SPI link whose data path is one, two or four lines wide. Software loads a byte FIFO with the whole command: the opcode first, then any address bytes, then one filler entry for every dummy byte and every byte it wants back. Software then pulses `start`. The opcode is decoded against a fixed table. The table says whether three address bytes follow, whether the data phase reads or writes, and how many lines the data phase uses. An opcode that is not in the table is rejected before the chip select ever falls, and an error interrupt is raised.

Each transmit entry becomes exactly one byte time on the wire, and every byte time pushes one byte into the receive FIFO. This includes the opcode, address and dummy bytes, so software throws away a known prefix. For example, a dual-lane read with three address bytes and two dummy bytes delivers its first valid byte as the seventh receive entry. The serial clock runs at half the system clock in SPI mode 0. The transaction ends when the transmit FIFO runs dry. The `clear` input empties both FIFOs and drops the interrupt, and should be pulsed before each new command is loaded.

Top module: `mio_flash_seq`

## Requirements
- R1: On `start` with a non-empty transmit FIFO while idle, the first entry is taken as the opcode and looked up. The supported opcodes are 0x03, 0x0B, 0x02, 0x3B and 0x6B, which have 3 address bytes, and 0x05, 0x9F and 0x06, which have none. 0x02 and 0x06 write; all others read. 0x3B has a 2-lane data phase, 0x6B has a 4-lane data phase, and every other opcode uses 1 lane.
- R2: An opcode outside the table sets `cmd_err_irq`. Chip select stays high, SCLK stays low, `busy` stays low and no receive byte is produced. The interrupt holds until `clear`.
- R3: The opcode and the address bytes go out MSB first on IO0 alone, with `io_oe` = 4'b0001.
- R4: For write opcodes, every entry after the address goes out on the table's data lanes with those lanes enabled.
- R5: For read opcodes, all four output enables are low from the first byte after the last address byte (or after the opcode, if it has no address) until chip select rises.
- R6: Lane mapping when driving and sampling: 1 lane drives IO0 and samples IO1. In 2-lane mode, IO1 carries the higher bit of each pair. In 4-lane mode, IO3 carries the highest bit of each nibble.
- R7: Each transmit entry yields exactly one byte time and one receive FIFO byte, in order. The number of byte times equals the number of transmit entries.
- R8: SPI mode 0 timing: SCLK is low whenever chip select is high. Each bit group has one system-clock cycle with SCLK low followed by one with SCLK high. Outputs change only while SCLK is low. There are no gaps between bytes.
- R9: `busy` is high from the cycle after an accepted `start` until chip select rises. Chip select rises only after the last receive byte has been written to the FIFO.
- R10: `clear` empties both FIFOs and drops `cmd_err_irq`.
- R11: `start` is ignored while busy or while the transmit FIFO is empty.
- R12: After reset, chip select is high, SCLK and all output enables are low, `busy` and `cmd_err_irq` are low, and the receive FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Empties both FIFOs and drops the error interrupt |
| tx_wr | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Transmit entry |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rd | input | 1 | Pop the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| start | input | 1 | Begin the loaded command |
| busy | output | 1 | A transaction is running |
| cmd_err_irq | output | 1 | Unsupported opcode seen |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Output values for IO3..IO0 |
| io_oe | output | 4 | Per-line output enables |
| io_in | input | 4 | Input values from IO3..IO0 |

## Verification
The bound checker watches the following on every cycle:
- the SCLK idle level and the stability of outputs during the SCLK-high half;
- the legal output-enable shapes;
- that chip select rises only after a receive push;
- that `busy` covers the whole chip-select window;
- the quiet aftermath of a rejected opcode.

Only the bench scenarios can show the remaining behaviours:
- that each opcode picks the right lane count and direction per phase;
- that bits are mapped onto the lines in the right order;
- that the received prefix lines up byte for byte with the transmit entries;
- that a cleared FIFO really holds nothing.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lanes_t;
  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_ADDR = 2'd1, PH_DATA = 2'd2} phase_t;

  typedef struct packed {
    logic   ok;
    logic   has_addr;
    logic   rd;
    lanes_t lanes;
  } op_info_t;

  // Built-in opcode table
  function automatic op_info_t op_lookup(input logic [7:0] op);
    op_info_t r;
    r.ok = 1'b1;
    r.has_addr = 1'b0;
    r.rd = 1'b1;
    r.lanes = LN_1;
    case (op)
      8'h03, 8'h0B: r.has_addr = 1'b1;
      8'h3B: begin r.has_addr = 1'b1; r.lanes = LN_2; end
      8'h6B: begin r.has_addr = 1'b1; r.lanes = LN_4; end
      8'h05, 8'h9F: r.rd = 1'b1;
      8'h06: r.rd = 1'b0;
      8'h02: begin r.has_addr = 1'b1; r.rd = 1'b0; end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] beats_of(input lanes_t l);
    case (l)
      LN_2: return 4'd4;
      LN_4: return 4'd2;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input lanes_t l);
    case (l)
      LN_2: return 4'b0011;
      LN_4: return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  // Bits presented on IO3..IO0 for the current group (MSB first)
  function automatic logic [3:0] drive_bits(input logic [7:0] b, input lanes_t l);
    case (l)
      LN_2: return {2'b00, b[7:6]};
      LN_4: return b[7:4];
      default: return {3'b000, b[7]};
    endcase
  endfunction

  function automatic logic [7:0] shift_out(input logic [7:0] b, input lanes_t l);
    case (l)
      LN_2: return {b[5:0], 2'b00};
      LN_4: return {b[3:0], 4'b0000};
      default: return {b[6:0], 1'b0};
    endcase
  endfunction

  // Single lane samples IO1; wider modes take the low lanes, highest line = highest bit
  function automatic logic [7:0] shift_in(input logic [7:0] acc, input logic [3:0] io,
                                          input lanes_t l);
    case (l)
      LN_2: return {acc[5:0], io[1:0]};
      LN_4: return {acc[3:0], io[3:0]};
      default: return {acc[6:0], io[1]};
    endcase
  endfunction

  function automatic phase_t phase_of(input int unsigned idx, input logic has_addr,
                                      input int unsigned n_addr);
    if (idx == 0) return PH_CMD;
    if (has_addr && idx <= n_addr) return PH_ADDR;
    return PH_DATA;
  endfunction

endpackage

// File: rtl/mfs_fifo.sv
module mfs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16  // power of two
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
endmodule

// File: rtl/mfs_lane_shifter.sv
module mfs_lane_shifter
  import mfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       step,
  input  lanes_t     lanes,
  input  logic [3:0] io_in,
  output logic [3:0] io_bits,
  output logic [7:0] cap_byte
);
  logic [7:0] sh_out, sh_in;

  assign io_bits  = drive_bits(sh_out, lanes);
  assign cap_byte = shift_in(sh_in, io_in, lanes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_out <= '0;
      sh_in  <= '0;
    end else begin
      if (load)      sh_out <= load_byte;
      else if (step) sh_out <= shift_out(sh_out, lanes);
      if (step)      sh_in  <= cap_byte;
    end
  end
endmodule

// File: rtl/mio_flash_seq.sv
module mio_flash_seq
  import mfs_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  output logic       tx_full,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       rx_empty,
  input  logic       start,
  output logic       busy,
  output logic       cmd_err_irq,
  output logic       sclk,
  output logic       cs_n,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  input  logic [3:0] io_in
);
  localparam int IDX_W   = $clog2(ADDR_BYTES + 2);
  localparam int IDX_SAT = ADDR_BYTES + 1;

  typedef enum logic {ST_IDLE, ST_RUN} st_t;

  st_t        st;
  logic       ph_hi;
  logic [3:0] beat;
  logic [IDX_W-1:0] bidx;
  op_info_t   info;
  logic       cs_q, irq_q;

  logic       tx_empty, tx_pop, rx_full;
  logic [7:0] tx_q, cap_byte;
  logic [3:0] io_bits;

  // Named events for the checker
  logic   start_ok, launch_ev, reject_ev, step_ev, byte_end, rx_push, more;
  logic   drive;
  phase_t cur_ph;
  lanes_t cur_lanes;
  op_info_t look;

  assign look      = op_lookup(tx_q);
  assign start_ok  = (st == ST_IDLE) && start && !tx_empty;
  assign launch_ev = start_ok && look.ok;
  assign reject_ev = start_ok && !look.ok;

  assign cur_ph    = phase_of(32'(bidx), info.has_addr, ADDR_BYTES);
  assign cur_lanes = (cur_ph == PH_DATA) ? info.lanes : LN_1;
  assign drive     = (cur_ph != PH_DATA) || !info.rd;

  assign step_ev  = (st == ST_RUN) && ph_hi;
  assign byte_end = step_ev && (beat == beats_of(cur_lanes) - 4'd1);
  assign more     = !tx_empty;
  assign rx_push  = byte_end;
  assign tx_pop   = start_ok || (byte_end && more);

  mfs_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .push(tx_wr), .din(tx_data), .pop(tx_pop), .dout(tx_q),
    .empty(tx_empty), .full(tx_full)
  );

  mfs_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .push(rx_push), .din(cap_byte), .pop(rx_rd), .dout(rx_data),
    .empty(rx_empty), .full(rx_full)
  );

  mfs_lane_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(launch_ev || (byte_end && more)), .load_byte(tx_q),
    .step(step_ev), .lanes(cur_lanes), .io_in(io_in),
    .io_bits(io_bits), .cap_byte(cap_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      ph_hi <= 1'b0;
      beat  <= '0;
      bidx  <= '0;
      info  <= '0;
      cs_q  <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      if (reject_ev)  irq_q <= 1'b1;
      else if (clear) irq_q <= 1'b0;

      case (st)
        ST_IDLE: begin
          if (launch_ev) begin
            st    <= ST_RUN;
            info  <= look;
            bidx  <= '0;
            beat  <= '0;
            ph_hi <= 1'b0;
            cs_q  <= 1'b0;
          end
        end
        default: begin
          ph_hi <= !ph_hi;
          if (step_ev) begin
            if (byte_end) begin
              beat <= '0;
              if (more) begin
                if (bidx != IDX_W'(IDX_SAT)) bidx <= bidx + 1'b1;
              end else begin
                st   <= ST_IDLE;
                cs_q <= 1'b1;
              end
            end else begin
              beat <= beat + 4'd1;
            end
          end
        end
      endcase
    end
  end

  assign busy        = (st == ST_RUN);
  assign cmd_err_irq = irq_q;
  assign sclk        = ph_hi;
  assign cs_n        = cs_q;
  assign io_oe       = (busy && drive) ? lane_mask(cur_lanes) : 4'b0000;
  assign io_out      = (busy && drive) ? io_bits : 4'b0000;
endmodule

// File: rtl/mio_flash_seq_chk.sv
module mio_flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       cs_n,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic       busy,
  input logic       irq,
  input logic       rx_push,
  input logic       rx_full,
  input logic       reject_ev
);
  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_hold_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> ($stable(io_out) && $stable(io_oe)));

  assert_oe_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

  assert_oe_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));

  assert_cs_after_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(rx_push));

  assert_busy_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (cs_n && !busy && irq));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
endmodule

bind mio_flash_seq mio_flash_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
  .io_oe(io_oe), .busy(busy), .irq(cmd_err_irq), .rx_push(rx_push),
  .rx_full(rx_full), .reject_ev(reject_ev)
);

// File: tb/mio_flash_seq_test.sv
module mio_flash_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n, clear, tx_wr, rx_rd, start;
  logic [7:0] tx_data, rx_data;
  logic tx_full, rx_empty, busy, cmd_err_irq, sclk, cs_n;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = 4'h0;

  mio_flash_seq uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_full(tx_full), .rx_rd(rx_rd), .rx_data(rx_data), .rx_empty(rx_empty),
    .start(start), .busy(busy), .cmd_err_irq(cmd_err_irq), .sclk(sclk),
    .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Transaction context shared by driver and flash model / monitor
  int t_n = 0;
  bit t_addr = 1'b0;
  bit t_rd = 1'b1;
  int t_ln = 1;
  int exp_hi = 0;
  logic [7:0] t_resp [16];
  logic [7:0] txb [$];
  logic [7:0] wire_q [$];
  logic [7:0] rx_q [$];

  // Opcode table restated from the requirements (R1)
  task automatic bench_op(input logic [7:0] op, output bit ok, output bit ha,
                          output bit rd, output int ln);
    ok = 1'b1; ha = 1'b0; rd = 1'b1; ln = 1;
    case (op)
      8'h03, 8'h0B: ha = 1'b1;
      8'h3B: begin ha = 1'b1; ln = 2; end
      8'h6B: begin ha = 1'b1; ln = 4; end
      8'h05, 8'h9F: ;
      8'h06: rd = 1'b0;
      8'h02: begin ha = 1'b1; rd = 1'b0; end
      default: ok = 1'b0;
    endcase
  endtask

  function automatic bit is_hdr(input int k);
    return (k == 0) || (t_addr && k <= 3);
  endfunction
  function automatic int b_lanes(input int k);
    return is_hdr(k) ? 1 : t_ln;
  endfunction
  function automatic bit b_drive(input int k);
    return is_hdr(k) || !t_rd;
  endfunction
  function automatic logic [3:0] mask_of(input int l);
    return (l == 1) ? 4'b0001 : (l == 2) ? 4'b0011 : 4'b1111;
  endfunction

  // Flash model + wire monitor (scoreboard consumer)
  int mk = 0;
  int mj = 0;
  int hi_cnt = 0;
  logic [7:0] macc = 8'h00;
  logic prev_cs = 1'b1;
  bit oe_bad = 1'b0;

  always @(negedge clk) begin
    int l;
    logic [7:0] r;
    logic [7:0] e;
    if (rst_n && !cs_n) begin
      l = b_lanes(mk);
      if (!sclk) begin
        r = t_resp[mk & 15] << (mj * l);
        case (l)
          1: io_in = {2'b10, r[7], ~r[7]};
          2: io_in = {2'b01, r[7:6]};
          default: io_in = r[7:4];
        endcase
      end else begin
        hi_cnt++;
        if (io_oe !== (b_drive(mk) ? mask_of(l) : 4'h0)) oe_bad = 1'b1;
        case (l)
          1: macc = {macc[6:0], io_out[0]};
          2: macc = {macc[5:0], io_out[1:0]};
          default: macc = {macc[3:0], io_out[3:0]};
        endcase
        if (mj == 8 / l - 1) begin
          chk(!oe_bad, b_drive(mk) ? "R3 output enable" : "R5 read enables low",
              int'(io_oe), b_drive(mk) ? int'(mask_of(l)) : 0);
          oe_bad = 1'b0;
          if (b_drive(mk)) begin
            e = (wire_q.size() > 0) ? wire_q.pop_front() : 8'h00;
            chk(macc == e, is_hdr(mk) ? "R3 header byte on wire" : "R4 write data on wire",
                int'(macc), int'(e));
          end
          mj = 0;
          mk++;
        end else begin
          mj++;
        end
      end
    end else begin
      if (rst_n && !prev_cs) begin
        chk(!rx_empty, "R9 rx byte present at cs rise", int'(rx_empty), 0);
        chk(mk == t_n, "R7 byte times", mk, t_n);
        chk(hi_cnt == exp_hi, "R8 sclk high cycles", hi_cnt, exp_hi);
      end
      mk = 0; mj = 0; hi_cnt = 0;
      io_in = 4'h0;
    end
    prev_cs = cs_n;
  end

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Driver: loads txb, pushes expectations, runs and drains
  task automatic run_txn(input int seed, input bit poke, input bit read_back);
    bit ok, ha, rd;
    int ln;
    int n;
    n = txb.size();
    do_clear();
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_wr = 1'b1; tx_data = txb[i];
    end
    @(negedge clk); tx_wr = 1'b0;
    bench_op(txb[0], ok, ha, rd, ln);
    t_addr = ha; t_rd = rd; t_ln = ln; t_n = n; exp_hi = 0;
    for (int k = 0; k < n; k++) begin
      t_resp[k] = 8'(k * 29 + seed) ^ 8'hC6;
      exp_hi += 8 / b_lanes(k);
      if (ok) begin
        if (b_drive(k)) wire_q.push_back(txb[k]);
        rx_q.push_back(t_resp[k]);
      end
    end
    pulse_start();
    if (ok) begin
      chk(busy && !cs_n, "R9 busy after start", int'(busy), 1);
      if (poke) begin
        repeat (5) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(wire_q.size() == 0, "R3 all driven bytes seen", wire_q.size(), 0);
      chk(!busy && cs_n, "R11 no restart after poke", int'(busy), 0);
      if (read_back) begin
        for (int i = 0; i < n; i++) begin
          chk(!rx_empty && rx_data == rx_q[0], (b_lanes(i) > 1) ? "R6 lane sampling" : "R7 rx byte",
              int'(rx_data), int'(rx_q[0]));
          void'(rx_q.pop_front());
          rx_rd = 1'b1;
          @(negedge clk); rx_rd = 1'b0;
        end
        chk(rx_empty, "R7 rx count", int'(rx_empty), 1);
      end
    end else begin
      int bad;
      bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (!cs_n || sclk || busy) bad++;
      end
      chk(cmd_err_irq, "R2 irq", int'(cmd_err_irq), 1);
      chk(bad == 0, "R2 no transaction", bad, 0);
      chk(rx_empty, "R2 no rx bytes", int'(rx_empty), 1);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=%0h expected=%0h", busy, 0);
    finish_run();
  end

  initial begin
    int quiet;
    rst_n = 1'b0; clear = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; start = 1'b0; tx_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(cs_n && !sclk, "R12 cs/sclk", int'({cs_n, sclk}), 2);
    chk(io_oe == 4'h0, "R12 oe", int'(io_oe), 0);
    chk(!busy && !cmd_err_irq, "R12 busy/irq", int'({busy, cmd_err_irq}), 0);
    chk(rx_empty, "R12 rx empty", int'(rx_empty), 1);

    // R11: start with empty transmit FIFO
    pulse_start();
    quiet = 0;
    repeat (10) begin @(negedge clk); if (busy || !cs_n) quiet++; end
    chk(quiet == 0, "R11 empty start ignored", quiet, 0);

    // R1 single-lane read
    txb = {8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00};
    run_txn(1, 1'b0, 1'b1);
    // R6 dual read: cmd + 3 addr + 2 dummy + 2 data (valid from 7th byte), with poke R11
    txb = {8'h3B, 8'hA1, 8'hB2, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00};
    run_txn(7, 1'b1, 1'b1);
    // R6 quad read
    txb = {8'h6B, 8'h0F, 8'hF0, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_txn(13, 1'b0, 1'b1);
    // R5 read without address
    txb = {8'h05, 8'h00, 8'h00};
    run_txn(21, 1'b0, 1'b1);
    txb = {8'h9F, 8'h00, 8'h00, 8'h00};
    run_txn(33, 1'b0, 1'b1);
    // R4 write
    txb = {8'h02, 8'h00, 8'h10, 8'h20, 8'hDE, 8'hAD, 8'h81};
    run_txn(44, 1'b0, 1'b1);
    txb = {8'h06};
    run_txn(50, 1'b0, 1'b1);
    txb = {8'h0B, 8'h7E, 8'h01, 8'h80, 8'h00, 8'h00};
    run_txn(61, 1'b0, 1'b1);

    // R2 unsupported opcodes
    txb = {8'h55, 8'h01, 8'h02};
    run_txn(70, 1'b0, 1'b1);
    txb = {8'hEB, 8'h01};
    run_txn(71, 1'b0, 1'b1);
    // R10 clear drops the interrupt
    do_clear();
    @(negedge clk);
    chk(!cmd_err_irq, "R10 irq cleared", int'(cmd_err_irq), 0);

    // R10 clear empties the receive FIFO
    txb = {8'h05, 8'h00, 8'h00};
    run_txn(80, 1'b0, 1'b0);
    rx_q.delete();
    do_clear();
    @(negedge clk);
    chk(rx_empty, "R10 rx emptied", int'(rx_empty), 1);

    // R10 clear empties the transmit FIFO: start after clear does nothing
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tx_wr = 1'b1; tx_data = 8'h03;
    end
    @(negedge clk); tx_wr = 1'b0;
    do_clear();
    pulse_start();
    quiet = 0;
    repeat (10) begin @(negedge clk); if (busy || !cs_n) quiet++; end
    chk(quiet == 0, "R10 tx emptied", quiet, 0);

    finish_run();
  end
endmodule